// File: doc/BRIEF.md
# Embedded-Clock Word Deserializer with Lock

This block turns an already-sampled serial stream, one bit per clock when a valid strobe is high, into 10-bit words. Every frame on the line is twelve bits long: a high start bit, ten payload bits and a low stop bit. The fixed one-then-zero pair around each payload is the only timing reference the stream carries, and the block uses it to find where frames begin.

While unlocked, the block hunts for the frame boundary. It tests a candidate boundary, and each time the candidate fails it moves the boundary one bit later. Once it has found a good boundary, it counts consecutive good frames. When the count reaches a fixed number, the block declares lock. It presents each word with a one-cycle strobe and holds an active-low lock flag low while words are valid. Lock is dropped only after a fixed number of consecutive frames with broken clock bits.

A low output enable blanks the data and strobe but leaves the internal state running. A low power-enable clears everything, and alignment then starts again from nothing.

Top module: `ecw_deser`

## Requirements
- R1: The first bit of a frame is the start bit (1), the next ten bits are payload bits 0 to 9 in that order, and the last bit is the stop bit (0). A delivered word_o carries payload bit k at bit k.
- R2: While hunting, every candidate boundary that fails the start=1/stop=0 test moves the boundary one bit later, so lock is reached from any bit offset of the incoming stream.
- R3: lock_no falls in the cycle after the last bit of the 80th consecutive good frame (LOCK_FRAMES). In that same cycle word_stb_o pulses for the first time, carrying that frame's payload.
- R4: During acquisition, a frame with bad clock bits restarts the good-frame count from zero.
- R5: While locked, the last bit of every delivered frame causes word_stb_o to be high for exactly one cycle in the following cycle, with word_o holding that frame's payload.
- R6: While locked, a single bad frame keeps lock and its word is still delivered. A second consecutive bad frame (LOSS_FRAMES=2) raises lock_no in the cycle after its last bit, with no strobe for that frame, and hunting restarts.
- R7: While lock_no is high, word_o is 0, word_stb_o is 0 and oe_o is 0.
- R8: While out_en_i is low, word_o is 0, word_stb_o is 0 and oe_o is 0, and lock_no and the alignment state are unaffected. When out_en_i returns high, words resume at the next frame end.
- R9: pwr_en_i low clears lock (lock_no high in the next cycle) and disables the outputs. When it returns high, a full LOCK_FRAMES good-frame run is needed again.
- R10: Cycles with bit_vld_i low neither shift bits nor advance any count, so gaps in the stream do not change when lock is reached.
- R11: After reset, lock_no is 1, oe_o is 0, word_o is 0 and word_stb_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_en_i | input | 1 | Low: power down, clear state, disable outputs |
| out_en_i | input | 1 | Low: blank data and strobe outputs |
| bit_i | input | 1 | Sampled serial bit |
| bit_vld_i | input | 1 | bit_i is valid this cycle |
| word_o | output | 10 | Deserialized payload word, zero while disabled |
| word_stb_o | output | 1 | One-cycle strobe marking a new word |
| lock_no | output | 1 | Lock flag, active low |
| oe_o | output | 1 | Outputs are enabled and carry valid data |

## Verification
The bench builds the block with its default parameters: 10-bit payload, a lock run of 80 good frames, and a loss threshold of 2 frames. With these values, the exact lock cycle can be measured against a count of frames kept in the bench. The one-miss/two-miss boundary of lock loss is also in reach. Acquisition runs are made from a non-zero bit offset, with gaps in the valid strobe, after a broken run and after power-down. Each run is compared every cycle against a behavioural model.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
  typedef enum logic {ST_HUNT, ST_LOCK} lock_st_e;
endpackage

// File: rtl/ecw_frame_align.sv
module ecw_frame_align #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_i,
  input  logic              vld_i,
  input  logic              keep_i,
  output logic              frm_end_o,
  output logic              frm_ok_o,
  output logic [DATA_W-1:0] payload_o
);
  localparam int FRM_LEN = DATA_W + 2;
  localparam int CW = $clog2(FRM_LEN);
  localparam logic [CW-1:0] LAST = CW'(FRM_LEN - 1);

  logic [FRM_LEN-2:0] sr_q;
  logic [CW-1:0]      cnt_q;
  logic [FRM_LEN-1:0] win;

  // oldest bit at the top of the window
  assign win       = {sr_q, bit_i};
  assign frm_end_o = vld_i && (cnt_q == LAST);
  assign frm_ok_o  = win[FRM_LEN-1] && !win[0];

  for (genvar k = 0; k < DATA_W; k++) begin : g_pay
    assign payload_o[k] = win[FRM_LEN-2-k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= LAST;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= LAST;
    end else if (vld_i) begin
      sr_q <= win[FRM_LEN-2:0];
      if (cnt_q == LAST) cnt_q <= (frm_ok_o || keep_i) ? '0 : LAST; // else slip one bit
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_end_o && (frm_ok_o || keep_i) && !clr_i) |=> !frm_end_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(cnt_q) && $stable(sr_q));
endmodule

// File: rtl/ecw_lock_fsm.sv
module ecw_lock_fsm
  import ecw_pkg::*;
#(
  parameter int LOCK_FRAMES = 80,
  parameter int LOSS_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic frm_end_i,
  input  logic frm_ok_i,
  output logic locked_o,
  output logic emit_o,
  output logic keep_o
);
  localparam int GW = $clog2(LOCK_FRAMES + 1);
  localparam int MW = $clog2(LOSS_FRAMES + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_FRAMES - 1);
  localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_FRAMES - 1);

  lock_st_e       st_q;
  logic [GW-1:0]  good_q;
  logic [MW-1:0]  miss_q;

  assign locked_o = (st_q == ST_LOCK);
  assign keep_o   = locked_o && (miss_q != MISS_LAST);
  assign emit_o   = frm_end_i &&
                    ((!locked_o && frm_ok_i && good_q == GOOD_LAST) ||
                     (locked_o && (frm_ok_i || miss_q != MISS_LAST)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      miss_q <= '0;
    end else if (clr_i) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      miss_q <= '0;
    end else if (frm_end_i) begin
      unique case (st_q)
        ST_HUNT: begin
          if (!frm_ok_i)               good_q <= '0;
          else if (good_q == GOOD_LAST) begin
            st_q   <= ST_LOCK;
            good_q <= '0;
          end else                     good_q <= good_q + 1'b1;
        end
        ST_LOCK: begin
          if (frm_ok_i)                miss_q <= '0;
          else if (miss_q == MISS_LAST) begin
            st_q   <= ST_HUNT;
            miss_q <= '0;
          end else                     miss_q <= miss_q + 1'b1;
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  // R3
  good_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_q <= GOOD_LAST);
  // R6
  miss_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> miss_q == '0);
  // R4
  acq_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_end_i && !frm_ok_i && !locked_o) |=> good_q == '0);
endmodule

// File: rtl/ecw_deser.sv
module ecw_deser #(
  parameter int DATA_W      = 10,
  parameter int LOCK_FRAMES = 80,
  parameter int LOSS_FRAMES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_en_i,
  input  logic              out_en_i,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_stb_o,
  output logic              lock_no,
  output logic              oe_o
);
  logic              clr;
  logic              frm_end, frm_ok, keep, locked, emit;
  logic [DATA_W-1:0] payload, word_q;
  logic              stb_q;

  assign clr = !pwr_en_i;

  ecw_frame_align #(.DATA_W(DATA_W)) u_align (
    .clk_i, .rst_ni, .clr_i(clr), .bit_i, .vld_i(bit_vld_i), .keep_i(keep),
    .frm_end_o(frm_end), .frm_ok_o(frm_ok), .payload_o(payload)
  );

  ecw_lock_fsm #(.LOCK_FRAMES(LOCK_FRAMES), .LOSS_FRAMES(LOSS_FRAMES)) u_lock (
    .clk_i, .rst_ni, .clr_i(clr), .frm_end_i(frm_end), .frm_ok_i(frm_ok),
    .locked_o(locked), .emit_o(emit), .keep_o(keep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else if (clr) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= emit;
      if (emit) word_q <= payload;
    end
  end

  assign lock_no    = !locked;
  assign oe_o       = out_en_i && pwr_en_i && locked;
  assign word_o     = oe_o ? word_q : '0;
  assign word_stb_o = oe_o && stb_q;

  // R5
  stb_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> !lock_no);
  // R3
  lock_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_no) |-> stb_q);
  // R6
  unlock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_no) |-> $past(!pwr_en_i || (frm_end && !frm_ok)));
  // R9
  pwr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |=> lock_no);
endmodule

// File: tb/sim_ecw_deser.sv
module sim_ecw_deser;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_en = 1'b0, out_en = 1'b0, bit_in = 1'b0, bit_vld = 1'b0;
  logic [9:0] word;
  logic       word_stb, lock_n, oe;

  int checks = 0, errors = 0;
  logic pwr_r = 1'b1, oe_r = 1'b1;
  int frames_sent = 0, lock_at = -1;
  logic prev_lock_n = 1'b1;

  // behavioural model state
  logic [11:0] m_win;
  int          m_ph, m_good, m_miss;
  bit          m_lock, m_stb;
  logic [9:0]  m_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecw_deser u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr_en), .out_en_i(out_en),
    .bit_i(bit_in), .bit_vld_i(bit_vld), .word_o(word), .word_stb_o(word_stb),
    .lock_no(lock_n), .oe_o(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_win = '0; m_ph = 11; m_good = 0; m_miss = 0;
    m_lock = 0; m_stb = 0; m_word = '0;
  endtask

  task automatic compare();
    bit e_oe;
    e_oe = out_en && pwr_en && m_lock;
    chk("R1", word, e_oe ? m_word : 10'h0);
    chk("R5", word_stb, e_oe && m_stb);
    chk("R3", lock_n, !m_lock);
    chk("R7", oe, e_oe);
    if (prev_lock_n && !lock_n) lock_at = frames_sent;
    prev_lock_n = lock_n;
  endtask

  task automatic model_step();
    logic [11:0] w;
    bit ok, emit;
    if (!pwr_en) begin model_clear(); return; end
    m_stb = 0;
    if (!bit_vld) return;
    w = {m_win[10:0], bit_in};
    m_win = w;
    if (m_ph != 11) begin m_ph++; return; end
    ok = w[11] && !w[0];
    emit = 0;
    if (!m_lock) begin
      if (ok) begin
        m_ph = 0;
        if (m_good == 79) begin m_lock = 1; m_good = 0; emit = 1; end
        else m_good++;
      end else m_good = 0;
    end else begin
      if (ok) begin m_miss = 0; emit = 1; m_ph = 0; end
      else if (m_miss == 1) begin m_lock = 0; m_miss = 0; end
      else begin m_miss++; emit = 1; m_ph = 0; end
    end
    if (emit) begin
      for (int k = 0; k < 10; k++) m_word[k] = w[10-k];
      m_stb = 1;
    end
  endtask

  task automatic step(input logic b, input logic v);
    @(negedge clk);
    compare();
    pwr_en = pwr_r; out_en = oe_r; bit_in = b; bit_vld = v;
    model_step();
  endtask

  task automatic send_frame(input logic st, input logic [9:0] pay, input logic sp, input int gap);
    logic [11:0] f;
    f[0] = st;
    for (int k = 0; k < 10; k++) f[k+1] = pay[k];
    f[11] = sp;
    for (int i = 0; i < 12; i++) begin
      if (gap > 0 && (i % gap) == 3) step(1'b0, 1'b0);
      step(f[i], 1'b1);
    end
    frames_sent++;
  endtask

  task automatic good_frames(input int n, input int gap, input bit rnd);
    for (int i = 0; i < n; i++)
      send_frame(1'b1, rnd ? 10'($urandom) : 10'h0, 1'b0, gap);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", lock_n, 1); chk("R11", oe, 0); chk("R11", word, 0); chk("R11", word_stb, 0);

    // R2, R3: odd bit offset then zero-payload frames
    frames_sent = 0; lock_at = -1;
    repeat (5) step(1'b0, 1'b1);
    good_frames(40, 0, 0);
    step(1'b0, 1'b0);
    chk("R7", oe, 0); chk("R7", word, 0);
    good_frames(45, 0, 0);
    step(1'b0, 1'b0);
    chk("R3", lock_at, 80);
    chk("R2", lock_n, 0);

    // R1, R5: random locked traffic then a known word
    good_frames(20, 0, 1);
    send_frame(1'b1, 10'h2C5, 1'b0, 0);
    step(1'b0, 1'b0);
    chk("R1", word, 10'h2C5); chk("R5", word_stb, 1);
    step(1'b0, 1'b0);
    chk("R5", word_stb, 0);

    // R6: one miss keeps lock, two consecutive drop it
    send_frame(1'b0, 10'h0, 1'b0, 0);
    step(1'b0, 1'b0);
    chk("R6", lock_n, 0); chk("R6", word_stb, 1);
    good_frames(3, 0, 1);
    send_frame(1'b0, 10'h0, 1'b0, 0);
    send_frame(1'b0, 10'h0, 1'b0, 0);
    step(1'b0, 1'b0);
    chk("R6", lock_n, 1); chk("R6", word_stb, 0);

    // R10: relock with valid gaps
    frames_sent = 0; lock_at = -1;
    good_frames(82, 5, 0);
    step(1'b0, 1'b0);
    chk("R10", lock_at, 80);

    // R8: output enable low while locked
    oe_r = 1'b0;
    good_frames(2, 0, 1);
    step(1'b0, 1'b0);
    chk("R8", lock_n, 0); chk("R8", oe, 0); chk("R8", word, 0);
    oe_r = 1'b1;
    step(1'b0, 1'b0);
    send_frame(1'b1, 10'h155, 1'b0, 0);
    step(1'b0, 1'b0);
    chk("R8", word, 10'h155); chk("R8", word_stb, 1);

    // R9, R4: power down, partial run, broken frame, full run
    pwr_r = 1'b0;
    repeat (3) step(1'b0, 1'b1);
    pwr_r = 1'b1;
    step(1'b0, 1'b0);
    chk("R9", lock_n, 1); chk("R9", oe, 0);
    good_frames(30, 0, 0);
    step(1'b0, 1'b0);
    chk("R9", lock_n, 1);
    send_frame(1'b0, 10'h0, 1'b0, 0);
    frames_sent = 0; lock_at = -1;
    good_frames(81, 0, 0);
    step(1'b0, 1'b0);
    chk("R4", lock_at, 80);
    step(1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule